// File: doc/BRIEF.md
# Control Register Ownership Filter

This block stands between guest software and one control register whose bits are split between two owners. A per-bit ownership mask marks each bit as host-owned (mask bit 1) or guest-owned (mask bit 0). Host-owned bits are presented to the guest from a read shadow the host keeps. Guest-owned bits go straight to the real register. A guest write that would change a host-owned bit away from its shadow value is trapped.

For every request the block returns the read value, a trap flag, a write-accepted flag and the next value of the real register. All of these are registered, so each answer appears one clock after its request. The register width is 32 or 64 bits. Write enables are per bit or per lane, and the lane width is a parameter. With this, one unit serves full register moves, single-bit clears and short status-word loads. The register storage, instruction decode and the host trap handler are outside the block. The caller feeds the current register value in and stores `nxt_val` back.

Top module: `crs_shadow_unit`

## Requirements
- R1: While `rst_n` is low, all outputs are zero.
- R2: A full read (`rd_req`=1, `rd_part`=0) returns `(shadow & own_mask) | (cur_val & ~own_mask)` on `rd_data`, with `rd_vld`=1, one cycle after the request.
- R3: A partial read (`rd_req`=1, `rd_part`=1) returns the same merge on the low PART_W bits (default 16), with the bits above forced to zero.
- R4: A write raises `exit_o` one cycle later exactly when some bit that is enabled and host-owned has a `wr_data` value different from `shadow`.
- R5: A write that raises `exit_o` gives `nxt_val` equal to `cur_val`, so the register does not change.
- R6: A write that does not trap raises `wr_done`. Its `nxt_val` takes `wr_data` on the enabled guest-owned bits and keeps `cur_val` on the host-owned bits.
- R7: Bits outside the write enable keep `cur_val` and take no part in the trap comparison. A single-bit clear or a low-4-bit status load touches only those bits.
- R8: Enable bit i covers register bits [i*LANE_BITS +: LANE_BITS]. LANE_BITS is 1 (per-bit enables) by default.
- R9: A cycle with no request gives `rd_vld`=0, `exit_o`=0 and `wr_done`=0 one cycle later, and `nxt_val` equal to the previous `cur_val`.
- R10: `exit_o` and `wr_done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_mask | input | W | Ownership mask, 1 = host-owned |
| shadow | input | W | Read shadow for host-owned bits |
| cur_val | input | W | Current real register value |
| wr_req | input | 1 | Guest write request |
| wr_data | input | W | Value written by the guest |
| wr_en | input | W/LANE_BITS | Per-lane write enable |
| rd_req | input | 1 | Guest read request |
| rd_part | input | 1 | Read returns only the low PART_W bits |
| rd_data | output | W | Value returned to the guest |
| rd_vld | output | 1 | `rd_data` holds a read result |
| exit_o | output | 1 | Write trapped to the host |
| wr_done | output | 1 | Write accepted |
| nxt_val | output | W | Next real register value |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before use and is then released between edges. They also assume that the inputs are stable around each rising edge. The stimulus drives every input on the falling edge and samples on the following falling edge. Mask, shadow, register and data values are drawn at random from a fixed seed, and so are the enables. A few directed cases cover a single-bit clear, a low-4-bit load, all-host and all-guest masks, and a read issued together with a write.

// File: rtl/crs_pkg.sv
package crs_pkg;
   localparam int unsigned CRS_PART_W = 16;

   // Owner-based merge: host bits from shadow, guest bits from real value
   function automatic logic [63:0] crs_merge(input logic [63:0] msk,
                                             input logic [63:0] shd,
                                             input logic [63:0] val);
      return (shd & msk) | (val & ~msk);
   endfunction
endpackage

// File: rtl/crs_lane_expand.sv
module crs_lane_expand #(
   parameter int unsigned W         = 64,
   parameter int unsigned LANE_BITS = 1,
   localparam int unsigned EW       = W / LANE_BITS
) (
   input  logic [EW-1:0] lane_en,
   output logic [W-1:0]  bit_en
);
   initial begin
      if (W % LANE_BITS != 0) $error("W must be a multiple of LANE_BITS");
   end

   generate
      if (LANE_BITS == 1) begin : g_bit
         assign bit_en = lane_en;
      end else begin : g_lane
         for (genvar i = 0; i < EW; i++) begin : g_l
            assign bit_en[i*LANE_BITS +: LANE_BITS] = {LANE_BITS{lane_en[i]}};
         end
      end
   endgenerate
endmodule

// File: rtl/crs_read_merge.sv
module crs_read_merge #(
   parameter int unsigned W      = 64,
   parameter int unsigned PART_W = 16
) (
   input  logic [W-1:0] own_mask,
   input  logic [W-1:0] shadow,
   input  logic [W-1:0] cur_val,
   input  logic         part,
   output logic [W-1:0] rd_val
);
   import crs_pkg::*;
   logic [63:0] full64;
   logic [W-1:0] full;
   logic [W-1:0] keep;

   initial begin
      if (PART_W == 0 || PART_W > W) $error("PART_W out of range");
   end

   assign full64 = crs_merge(64'(own_mask), 64'(shadow), 64'(cur_val));
   assign full   = full64[W-1:0];

   generate
      if (PART_W == W) begin : g_nopart
         assign keep = '1;
      end else begin : g_part
         assign keep = part ? {{(W-PART_W){1'b0}}, {PART_W{1'b1}}} : '1;
      end
   endgenerate

   assign rd_val = full & keep;
endmodule

// File: rtl/crs_write_eval.sv
module crs_write_eval #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0] own_mask,
   input  logic [W-1:0] shadow,
   input  logic [W-1:0] cur_val,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] bit_en,
   output logic         trap,
   output logic [W-1:0] upd_val
);
   logic [W-1:0] host_cmp;
   logic [W-1:0] guest_wr;

   always_comb begin
      host_cmp = (wr_data ^ shadow) & own_mask & bit_en;
      guest_wr = bit_en & ~own_mask;
      trap     = |host_cmp;
      upd_val  = trap ? cur_val : ((cur_val & ~guest_wr) | (wr_data & guest_wr));
   end
endmodule

// File: rtl/crs_shadow_unit.sv
module crs_shadow_unit #(
   parameter int unsigned W         = 64,
   parameter int unsigned LANE_BITS = 1,
   parameter int unsigned PART_W    = crs_pkg::CRS_PART_W,
   localparam int unsigned EW       = W / LANE_BITS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  own_mask,
   input  logic [W-1:0]  shadow,
   input  logic [W-1:0]  cur_val,
   input  logic          wr_req,
   input  logic [W-1:0]  wr_data,
   input  logic [EW-1:0] wr_en,
   input  logic          rd_req,
   input  logic          rd_part,
   output logic [W-1:0]  rd_data,
   output logic          rd_vld,
   output logic          exit_o,
   output logic          wr_done,
   output logic [W-1:0]  nxt_val
);
   initial begin
      if (W != 32 && W != 64) $error("W must be 32 or 64");
   end

   logic [W-1:0] bit_en;
   logic [W-1:0] rd_val;
   logic [W-1:0] upd_val;
   logic         trap;

   crs_lane_expand #(.W(W), .LANE_BITS(LANE_BITS)) u_exp (
      .lane_en(wr_en), .bit_en(bit_en));

   crs_read_merge #(.W(W), .PART_W(PART_W)) u_rd (
      .own_mask(own_mask), .shadow(shadow), .cur_val(cur_val),
      .part(rd_part), .rd_val(rd_val));

   crs_write_eval #(.W(W)) u_wr (
      .own_mask(own_mask), .shadow(shadow), .cur_val(cur_val),
      .wr_data(wr_data), .bit_en(bit_en), .trap(trap), .upd_val(upd_val));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_vld  <= 1'b0;
         exit_o  <= 1'b0;
         wr_done <= 1'b0;
         nxt_val <= '0;
      end else begin
         rd_vld  <= rd_req;
         rd_data <= rd_req ? rd_val : '0;
         exit_o  <= wr_req & trap;
         wr_done <= wr_req & ~trap;
         nxt_val <= wr_req ? upd_val : cur_val;
      end
   end

   // R10: trap and accept are mutually exclusive
   p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(exit_o && wr_done));

   // R5: trapped write leaves register as it was
   p_trap_keeps_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      exit_o |-> (nxt_val == $past(cur_val)));

   // R6: accepted write never alters host-owned bits
   p_host_bits_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> (((nxt_val ^ $past(cur_val)) & $past(own_mask)) == '0));

   // R7: bits outside the enable keep their value
   p_disabled_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (((nxt_val ^ $past(cur_val)) & ~$past(bit_en)) == '0));

   // R9: outcomes only follow a request
   p_no_req_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exit_o || wr_done) |-> $past(wr_req));

   // R2: read valid only after a read request
   p_rd_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld |-> $past(rd_req));
endmodule

// File: tb/crs_shadow_unit_tb.sv
module crs_shadow_unit_tb;
   localparam int W = 64;
   localparam int PW = 16;

   logic         clk = 0;
   logic         rst_n = 0;
   logic [W-1:0] own_mask = '0, shadow = '0, cur_val = '0, wr_data = '0, wr_en = '0;
   logic         wr_req = 0, rd_req = 0, rd_part = 0;
   logic [W-1:0] rd_data, nxt_val;
   logic         rd_vld, exit_o, wr_done;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   crs_shadow_unit #(.W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .own_mask(own_mask), .shadow(shadow),
      .cur_val(cur_val), .wr_req(wr_req), .wr_data(wr_data), .wr_en(wr_en),
      .rd_req(rd_req), .rd_part(rd_part), .rd_data(rd_data), .rd_vld(rd_vld),
      .exit_o(exit_o), .wr_done(wr_done), .nxt_val(nxt_val));

   function automatic logic [W-1:0] exp_read(logic [W-1:0] m, logic [W-1:0] s,
                                              logic [W-1:0] v, logic p);
      logic [W-1:0] r;
      r = (s & m) | (v & ~m);
      if (p) r = r & {{(W-PW){1'b0}}, {PW{1'b1}}};
      return r;
   endfunction

   function automatic logic exp_trap(logic [W-1:0] m, logic [W-1:0] s,
                                     logic [W-1:0] d, logic [W-1:0] e);
      for (int i = 0; i < W; i++)
         if (m[i] && e[i] && (d[i] != s[i])) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [W-1:0] exp_upd(logic [W-1:0] m, logic [W-1:0] v,
                                            logic [W-1:0] d, logic [W-1:0] e, logic t);
      logic [W-1:0] r;
      r = v;
      if (!t) for (int i = 0; i < W; i++) if (e[i] && !m[i]) r[i] = d[i];
      return r;
   endfunction

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] expv);
      n_tests++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, expv);
      end
   endtask

   // drive on negedge, check on next negedge
   task automatic op(logic [W-1:0] m, logic [W-1:0] s, logic [W-1:0] v,
                     logic wq, logic [W-1:0] d, logic [W-1:0] e,
                     logic rq, logic p);
      logic t;
      logic [W-1:0] ev;
      own_mask = m; shadow = s; cur_val = v; wr_req = wq; wr_data = d;
      wr_en = e; rd_req = rq; rd_part = p;
      t  = wq && exp_trap(m, s, d, e);
      ev = wq ? exp_upd(m, v, d, e, t) : v;
      @(negedge clk);
      chk(p ? "R3 rd_data" : "R2 rd_data", rd_data, rq ? exp_read(m, s, v, p) : '0);
      chk("R2 rd_vld", {63'd0, rd_vld}, {63'd0, rq});
      chk("R4 exit_o", {63'd0, exit_o}, {63'd0, t});
      chk("R6 wr_done", {63'd0, wr_done}, {63'd0, wq && !t});
      chk(t ? "R5 nxt_val" : "R7 nxt_val", nxt_val, ev);
      chk("R10 exclusive", {63'd0, exit_o && wr_done}, '0);
      wr_req = 0; rd_req = 0;
   endtask

   function automatic logic [W-1:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      cur_val = '1; wr_req = 1; rd_req = 1; wr_en = '1; wr_data = '1;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 rd_data", rd_data, '0);
      chk("R1 nxt_val", nxt_val, '0);
      chk("R1 flags", {61'd0, rd_vld, exit_o, wr_done}, '0);
      wr_req = 0; rd_req = 0;
      rst_n = 1;
      // R9: idle cycle
      op(64'hF0F0, 64'h1234, 64'hABCD_0000_5555_AAAA, 0, '0, '0, 0, 0);
      // R2/R3 reads
      op(64'hFFFF_0000_FFFF_0000, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 0, '0, '0, 1, 0);
      op(64'hFFFF_0000_FFFF_00F0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 0, '0, '0, 1, 1);
      // R7: single-bit clear of guest bit 3
      op(64'h1, 64'h1, 64'hF, 1, 64'h0, 64'h8, 0, 0);
      // R7/R4: clear of host bit 0 differing from shadow traps
      op(64'h1, 64'h1, 64'hF, 1, 64'h0, 64'h1, 0, 0);
      // R7: low-4 status load; upper bits differ from shadow but not enabled
      op(64'hFFFF_FFFF_FFFF_FFF1, 64'h0, 64'h0, 1, 64'hFFFF_FFFF_FFFF_FFF1, 64'hF, 0, 0);
      op(64'hFFFF_FFFF_FFFF_FFF1, 64'h0, 64'h0, 1, 64'hFFFF_FFFF_FFFF_FFFE, 64'hF, 0, 0);
      // R6: all-guest mask full write
      op('0, rnd64(), 64'h0, 1, 64'hDEAD_BEEF_0BAD_F00D, '1, 1, 0);
      // R5: all-host mask write differing traps
      op('1, 64'h0, 64'h77, 1, 64'h1, '1, 1, 1);
      // R6/R8: all-host mask matching shadow accepted, register unchanged
      op('1, 64'h55, 64'h77, 1, 64'h55, '1, 0, 0);
      // constrained random
      for (int k = 0; k < 400; k++) begin
         logic [W-1:0] m, s, d, e;
         m = rnd64(); s = rnd64(); e = rnd64();
         d = ($urandom_range(0, 1) == 1) ? ((s & m) | (rnd64() & ~m)) : rnd64();
         if ($urandom_range(0, 3) == 0) e = 64'(1) << $urandom_range(0, 63);
         op(m, s, rnd64(), $urandom_range(0, 1) == 1, d, e,
            $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule